// File: doc/BRIEF.md
# Graphics Masked Write Datapath

This block is the write side of a 32-bit synchronous graphics memory interface. It decodes the command pins and keeps two 32-bit registers: a per-bit mask and a fill color. For each write command it produces one registered column-write strobe carrying the merged data word, a per-bit enable vector, and an enable for each column in an aligned 8-column group. The storage array that consumes the strobe is outside this block.

Normal writes merge the incoming word under active-high per-byte DQM masks. A row activate with the special-function pin high arms write-per-bit for that bank. While it is armed, every later write to that bank is also limited to the bits that are set in the mask register. The mask stays in force until it is loaded again. A write with the special-function pin high is a block write. It takes its data from the color register, aligns the column address down to a multiple of 8, and uses the low 8 data bits as individual column enables. A mode-set command with the special-function pin high loads either register from the data bus, chosen by address bit 5.

Top module: `sgw_write_path`

## Requirements
- R1: After a synchronous active-low reset, no strobe is issued, the mask register holds all ones and the color register holds zero.
- R2: A command given with `cs_n` high has no effect: it issues no strobe and changes no register.
- R3: A write (`ras_n`=1, `cas_n`=0, `we_n`=0, `dsf`=0) gives a strobe one cycle later. The strobe carries the bank, the column `addr[7:0]` and the data bus unchanged. Column enable bit `addr[2:0]` is the only one set. `wr_bit_en` bits 8i+7..8i are cleared exactly when `dqm[i]`=1.
- R4: A mode set (`ras_n`=`cas_n`=`we_n`=0) with `dsf`=1 issues no strobe. It loads the data bus into the mask register when `addr[5]`=0, or into the color register when `addr[5]`=1. A mode set with `dsf`=0 changes neither register.
- R5: An activate (`ras_n`=0, `cas_n`=1, `we_n`=1) on a bank turns write-per-bit on for that bank if `dsf`=1, or off if `dsf`=0. The other bank is left as it was. Write-per-bit is off for both banks after reset.
- R6: A write to a bank that has write-per-bit on gives `wr_bit_en` equal to the DQM byte enables ANDed with the mask register.
- R7: A block write (write with `dsf`=1) issues one strobe one cycle later. Its data is the color register and its column is `addr[7:0]` with bits 2..0 cleared. Column enable bit k equals data bit k, for k = 0..7.
- R8: A block write applies the DQM byte enables, and applies the mask register when its bank has write-per-bit on.
- R9: The mask register keeps its value across any number of writes. A write issued the cycle after a reload uses the new value.
- R10: Read, precharge, refresh and no-operation commands issue no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| bank | input | 1 | Bank address |
| addr | input | 8 | Column address; bit 5 is the register key during a mode set |
| dqm | input | 4 | Byte-lane masks, 1 = lane masked |
| wdata | input | 32 | Write data bus |
| wr_valid | output | 1 | Column write strobe |
| wr_bank | output | 1 | Bank of the strobe |
| wr_col | output | 8 | Column (aligned to 8 for a block write) |
| wr_col_en | output | 8 | Per-column enables within the aligned group |
| wr_data | output | 32 | Data word to store |
| wr_bit_en | output | 32 | Per-bit write enables |

## Verification
Each strobe, and each missing strobe, is due one rising edge after its command is sampled. The strobe comes from a single output register, and the datapath adds no further delay. Register loads and write-per-bit arming take effect at the same edge, so the very next command already sees them. The bench drives each command on the falling edge and queues one expected item for it. The bench compares the outputs 1 ns after the next rising edge, one item per cycle, so every comparison lands in the cycle its command is due.

// File: rtl/sgw_pkg.sv
// Shared types for the graphics write datapath.
// Assumes active-low command strobes sampled on the rising clock edge.
package sgw_pkg;

    typedef enum logic [2:0] {
        SGW_NOP,
        SGW_ACT,
        SGW_RD,
        SGW_WR,
        SGW_MODE,
        SGW_PRE,
        SGW_REF
    } sgw_cmd_e;

endpackage

// File: rtl/sgw_cmd_decode.sv
// Command decoder: turns the strobe pins into one command code plus
// qualified flags for the register and merge stages.
// Assumes cs_n high deselects the device; purely combinational.
module sgw_cmd_decode
    import sgw_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     dsf,
    output sgw_cmd_e cmd,
    output logic     is_write,
    output logic     is_block,
    output logic     is_special_load,
    output logic     is_activate
);

    // Map strobe pattern to a command; deselect maps to no-operation.
    always_comb begin
        cmd = SGW_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = SGW_ACT;
                3'b101:  cmd = SGW_RD;
                3'b100:  cmd = SGW_WR;
                3'b000:  cmd = SGW_MODE;
                3'b010:  cmd = SGW_PRE;
                3'b001:  cmd = SGW_REF;
                default: cmd = SGW_NOP;
            endcase
        end
    end

    // Qualify the commands that this datapath acts on.
    always_comb begin
        is_write        = (cmd == SGW_WR);
        is_block        = (cmd == SGW_WR) && dsf;
        is_special_load = (cmd == SGW_MODE) && dsf;
        is_activate     = (cmd == SGW_ACT);
    end

endmodule

// File: rtl/sgw_regs.sv
// Special registers: the per-bit mask, the fill color and one
// write-per-bit flag per bank.
// Assumes only one command per cycle, so a load never meets a write.
module sgw_regs #(
    parameter int DATA_W  = 32,
    parameter int NBANKS  = 2,
    parameter int BANK_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_color,
    input  logic [DATA_W-1:0] load_value,
    input  logic              act_en,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              act_dsf,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] color_q,
    output logic [NBANKS-1:0] wpb_q
);

    // Mask register: reset to all ones, reloaded only by a special load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (load_en && !load_color)
            mask_q <= load_value;
    end

    // Color register: reset to zero, reloaded only by a special load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            color_q <= '0;
        else if (load_en && load_color)
            color_q <= load_value;
    end

    // One write-per-bit flag per bank, set or cleared by an activate.
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                wpb_q[b] <= 1'b0;
            else if (act_en && (act_bank == BANK_W'(b)))
                wpb_q[b] <= act_dsf;
        end
    end

endmodule

// File: rtl/sgw_merge.sv
// Merge stage: builds the data word, bit enables and column enables
// for one write and registers them as the output strobe.
// Assumes BLK_COLS is a power of two no wider than the data bus.
module sgw_merge #(
    parameter int DATA_W   = 32,
    parameter int BYTE_W   = 8,
    parameter int COL_W    = 8,
    parameter int BLK_COLS = 8,
    parameter int NBANKS   = 2,
    parameter int BANK_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                blk_en,
    input  logic [BANK_W-1:0]   bank,
    input  logic [COL_W-1:0]    col,
    input  logic [DATA_W/BYTE_W-1:0] dqm,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   mask_q,
    input  logic [DATA_W-1:0]   color_q,
    input  logic [NBANKS-1:0]   wpb_q,
    output logic                wr_valid,
    output logic [BANK_W-1:0]   wr_bank,
    output logic [COL_W-1:0]    wr_col,
    output logic [BLK_COLS-1:0] wr_col_en,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   wr_bit_en
);

    localparam int LANES   = DATA_W / BYTE_W;
    localparam int ALIGN_W = $clog2(BLK_COLS);

    logic [DATA_W-1:0]   byte_en;
    logic [DATA_W-1:0]   bit_en_d;
    logic [DATA_W-1:0]   data_d;
    logic [BLK_COLS-1:0] col_en_d;
    logic [COL_W-1:0]    col_d;
    logic                wpb_sel;

    // Expand each lane mask into a run of bit enables.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign byte_en[i*BYTE_W +: BYTE_W] = {BYTE_W{~dqm[i]}};
    end

    // Pick data, columns and bit enables for a normal or block write.
    always_comb begin
        wpb_sel  = wpb_q[bank];
        bit_en_d = byte_en & (wpb_sel ? mask_q : {DATA_W{1'b1}});
        if (blk_en) begin
            data_d   = color_q;
            col_en_d = wdata[BLK_COLS-1:0];
            col_d    = {col[COL_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        end else begin
            data_d   = wdata;
            col_en_d = BLK_COLS'(1) << col[ALIGN_W-1:0];
            col_d    = col;
        end
    end

    // Output register: one strobe per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_bank   <= '0;
            wr_col    <= '0;
            wr_col_en <= '0;
            wr_data   <= '0;
            wr_bit_en <= '0;
        end else begin
            wr_valid <= wr_en;
            if (wr_en) begin
                wr_bank   <= bank;
                wr_col    <= col_d;
                wr_col_en <= col_en_d;
                wr_data   <= data_d;
                wr_bit_en <= bit_en_d;
            end
        end
    end

endmodule

// File: rtl/sgw_write_path.sv
// Top of the graphics write datapath: decodes commands, holds the
// mask and color registers, and issues merged column write strobes.
// Assumes the array behind it accepts one strobe per cycle.
module sgw_write_path
    import sgw_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BYTE_W   = 8,
    parameter int COL_W    = 8,
    parameter int BLK_COLS = 8,
    parameter int BANK_W   = 1,
    parameter int KEY_BIT  = 5,
    localparam int LANES   = DATA_W / BYTE_W,
    localparam int NBANKS  = 1 << BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                dsf,
    input  logic [BANK_W-1:0]   bank,
    input  logic [COL_W-1:0]    addr,
    input  logic [LANES-1:0]    dqm,
    input  logic [DATA_W-1:0]   wdata,
    output logic                wr_valid,
    output logic [BANK_W-1:0]   wr_bank,
    output logic [COL_W-1:0]    wr_col,
    output logic [BLK_COLS-1:0] wr_col_en,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   wr_bit_en
);

    sgw_cmd_e          cmd;
    logic              is_write;
    logic              is_block;
    logic              is_special_load;
    logic              is_activate;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] color_q;
    logic [NBANKS-1:0] wpb_q;

    sgw_cmd_decode u_dec (
        .cs_n            (cs_n),
        .ras_n           (ras_n),
        .cas_n           (cas_n),
        .we_n            (we_n),
        .dsf             (dsf),
        .cmd             (cmd),
        .is_write        (is_write),
        .is_block        (is_block),
        .is_special_load (is_special_load),
        .is_activate     (is_activate)
    );

    sgw_regs #(
        .DATA_W (DATA_W),
        .NBANKS (NBANKS),
        .BANK_W (BANK_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (is_special_load),
        .load_color (addr[KEY_BIT]),
        .load_value (wdata),
        .act_en     (is_activate),
        .act_bank   (bank),
        .act_dsf    (dsf),
        .mask_q     (mask_q),
        .color_q    (color_q),
        .wpb_q      (wpb_q)
    );

    sgw_merge #(
        .DATA_W   (DATA_W),
        .BYTE_W   (BYTE_W),
        .COL_W    (COL_W),
        .BLK_COLS (BLK_COLS),
        .NBANKS   (NBANKS),
        .BANK_W   (BANK_W)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (is_write),
        .blk_en    (is_block),
        .bank      (bank),
        .col       (addr),
        .dqm       (dqm),
        .wdata     (wdata),
        .mask_q    (mask_q),
        .color_q   (color_q),
        .wpb_q     (wpb_q),
        .wr_valid  (wr_valid),
        .wr_bank   (wr_bank),
        .wr_col    (wr_col),
        .wr_col_en (wr_col_en),
        .wr_data   (wr_data),
        .wr_bit_en (wr_bit_en)
    );

endmodule

// File: rtl/sgw_write_path_chk.sv
// Protocol checker for the write datapath, bound to the top module.
// Decodes the command pins on its own and checks the output strobe.
module sgw_write_path_chk #(
    parameter int DATA_W   = 32,
    parameter int COL_W    = 8,
    parameter int BLK_COLS = 8,
    parameter int LANES    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                ras_n,
    input logic                cas_n,
    input logic                we_n,
    input logic                dsf,
    input logic [LANES-1:0]    dqm,
    input logic                wr_valid,
    input logic [COL_W-1:0]    wr_col,
    input logic [BLK_COLS-1:0] wr_col_en,
    input logic [DATA_W-1:0]   wr_bit_en
);

    localparam int ALIGN_W = $clog2(BLK_COLS);

    logic c_wr;
    logic c_mode;

    // Independent decode of the write and mode-set patterns.
    always_comb begin
        c_wr   = !cs_n && ras_n && !cas_n && !we_n;
        c_mode = !cs_n && !ras_n && !cas_n && !we_n;
    end

    // R3
    normal_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && !dsf) |=> (wr_valid && $countones(wr_col_en) == 1));

    // R3
    all_lanes_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && (&dqm)) |=> (wr_valid && wr_bit_en == '0));

    // R7
    block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && dsf) |=> (wr_valid && wr_col[ALIGN_W-1:0] == '0));

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !wr_valid);

    // R4
    mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_mode |=> !wr_valid);

    // R10
    nonwrite_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !c_wr) |=> !wr_valid);

endmodule

bind sgw_write_path sgw_write_path_chk #(
    .DATA_W   (DATA_W),
    .COL_W    (COL_W),
    .BLK_COLS (BLK_COLS),
    .LANES    (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dsf       (dsf),
    .dqm       (dqm),
    .wr_valid  (wr_valid),
    .wr_col    (wr_col),
    .wr_col_en (wr_col_en),
    .wr_bit_en (wr_bit_en)
);

// File: tb/sgw_write_path_tb.sv
`timescale 1ns/1ps
module sgw_write_path_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
    logic        bank = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  dqm = '0;
    logic [31:0] wdata = '0;
    logic        wr_valid;
    logic        wr_bank;
    logic [7:0]  wr_col;
    logic [7:0]  wr_col_en;
    logic [31:0] wr_data;
    logic [31:0] wr_bit_en;

    typedef struct {
        logic        valid;
        logic        bank;
        logic [7:0]  col;
        logic [7:0]  col_en;
        logic [31:0] data;
        logic [31:0] bit_en;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] m_mask  = '1;
    logic [31:0] m_color = '0;
    logic [1:0]  m_wpb   = '0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sgw_write_path u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .dsf(dsf), .bank(bank), .addr(addr), .dqm(dqm),
        .wdata(wdata), .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_col(wr_col),
        .wr_col_en(wr_col_en), .wr_data(wr_data), .wr_bit_en(wr_bit_en)
    );

    function automatic logic [31:0] lanes(input logic [3:0] m);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? 8'h00 : 8'hFF;
        return r;
    endfunction

    // Drive one command at the falling edge and queue its expected result.
    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic d, input logic b, input logic [7:0] a,
                         input logic [3:0] m, input logic [31:0] v, input string req);
        exp_t e;
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; dsf = d;
        bank = b; addr = a; dqm = m; wdata = v;
        e.valid = 1'b0; e.bank = b; e.col = a; e.col_en = '0;
        e.data = '0; e.bit_en = '0; e.req = req;
        if (!c && r && !ca && !w) begin
            e.valid  = 1'b1;
            e.bit_en = lanes(m) & (m_wpb[b] ? m_mask : 32'hFFFF_FFFF);
            if (d) begin
                e.data = m_color; e.col = {a[7:3], 3'b000}; e.col_en = v[7:0];
            end else begin
                e.data = v; e.col_en = 8'(1) << a[2:0];
            end
        end else if (!c && !r && !ca && !w && d) begin
            if (a[5]) m_color = v; else m_mask = v;
        end else if (!c && !r && ca && w) begin
            m_wpb[b] = d;
        end
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic b, input logic [7:0] a, input logic [3:0] m,
                      input logic [31:0] v, input string req);
        drive(0, 1, 0, 0, 0, b, a, m, v, req);
    endtask
    task automatic blk(input logic b, input logic [7:0] a, input logic [3:0] m,
                       input logic [31:0] v, input string req);
        drive(0, 1, 0, 0, 1, b, a, m, v, req);
    endtask
    task automatic mode(input logic d, input logic key, input logic [31:0] v, input string req);
        drive(0, 0, 0, 0, d, 0, key ? 8'h20 : 8'h00, 4'h0, v, req);
    endtask
    task automatic act(input logic b, input logic d, input string req);
        drive(0, 0, 1, 1, d, b, 8'h00, 4'h0, 32'h0, req);
    endtask

    // Monitor: compare one queued item 1 ns after each rising edge.
    always begin
        exp_t e;
        @(posedge clk);
        #1;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_checks++;
            if (wr_valid !== e.valid ||
                (e.valid && (wr_bank !== e.bank || wr_col !== e.col ||
                 wr_col_en !== e.col_en || wr_data !== e.data || wr_bit_en !== e.bit_en))) begin
                n_errors++;
                $display("FAIL %s: got v=%b b=%b col=%h en=%h d=%h be=%h exp v=%b b=%b col=%h en=%h d=%h be=%h",
                         e.req, wr_valid, wr_bank, wr_col, wr_col_en, wr_data, wr_bit_en,
                         e.valid, e.bank, e.col, e.col_en, e.data, e.bit_en);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #20000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: got running exp finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle straight after reset
        n_checks++;
        if (wr_valid !== 1'b0 || wr_bit_en !== '0) begin
            n_errors++;
            $display("FAIL R1: got v=%b be=%h exp v=0 be=0", wr_valid, wr_bit_en);
        end
        wr(0, 8'h13, 4'b0000, 32'hA5A5_1234, "R3");
        wr(1, 8'h47, 4'b0101, 32'h1357_9BDF, "R3");
        blk(0, 8'h0E, 4'b0000, 32'h0000_00C3, "R1_R7");
        act(0, 1, "R5");
        wr(0, 8'h02, 4'b0000, 32'hFFFF_0000, "R1_R6");
        mode(1, 0, 32'h0F0F_F00F, "R4");
        wr(0, 8'h05, 4'b0000, 32'h1111_2222, "R6_R9");
        wr(0, 8'h06, 4'b1000, 32'h3333_4444, "R6");
        wr(1, 8'h07, 4'b0000, 32'h5555_6666, "R5");
        mode(1, 1, 32'hDEAD_BEEF, "R4");
        blk(0, 8'h2D, 4'b0000, 32'h0000_00A5, "R7_R8");
        mode(0, 0, 32'h0000_0000, "R4");
        wr(0, 8'h10, 4'b0000, 32'h7777_8888, "R4_R9");
        drive(1, 1, 0, 0, 0, 0, 8'h11, 4'b0000, 32'h9999_AAAA, "R2");
        drive(1, 0, 0, 0, 1, 0, 8'h00, 4'b0000, 32'h0000_0000, "R2");
        wr(0, 8'h12, 4'b0000, 32'hBBBB_CCCC, "R2_R9");
        drive(0, 1, 0, 1, 0, 0, 8'h20, 4'b0000, 32'h0, "R10");
        drive(0, 0, 1, 0, 0, 1, 8'h00, 4'b0000, 32'h0, "R10");
        drive(0, 0, 0, 1, 0, 0, 8'h00, 4'b0000, 32'h0, "R10");
        drive(0, 1, 1, 1, 0, 0, 8'h00, 4'b0000, 32'h0, "R10");
        act(1, 1, "R5");
        act(0, 0, "R5");
        wr(0, 8'h30, 4'b0000, 32'hCAFE_0001, "R5");
        blk(1, 8'hFF, 4'b0011, 32'h0000_0081, "R8");
        mode(1, 0, 32'hFFFF_0000, "R9");
        wr(1, 8'h44, 4'b0000, 32'h0BAD_F00D, "R9");
        blk(1, 8'h08, 4'b1111, 32'h0000_0000, "R3_R8");
        drive(0, 1, 1, 1, 0, 0, 8'h00, 4'b0000, 32'h0, "R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule